// File: doc/BRIEF.md
# Cascaded Master Clock Prescaler

The block turns one free-running master clock into two clock-enable strobes for the converter logic downstream. Three divider stages sit in series, and each one has its own 2-bit ratio select. The first stage counts every clock cycle once the block is out of reset. Each later stage counts only the cycles in which the stage before it fires. The last stage produces the internal master tick. A fixed 256:1 counter then divides that tick down to the sample-rate strobe.

No derived clock is made. Both outputs are one-cycle-wide enables in the input clock domain. A single configuration write loads all three selects at once. The same write restarts every counter from zero, so that no partial period follows the change.

Top module: `mclk_prescaler`

## Requirements
- R1: While `rst_ni` is low, and in the first clock cycle after it is released, both strobes are low. The configuration resets to 6'b000000, which gives an overall ratio of 1.
- R2: A write is a cycle with `cfg_we_i` high. It loads `cfg_wdata_i` into the configuration. Bits [1:0] select stage A, bits [3:2] select stage B and bits [5:4] select stage C.
- R3: Stage A select codes: 2'b00 divides by 1, 2'b01 by 2 and 2'b10 by 3.
- R4: Stage B select codes: 2'b00 divides by 1, 2'b01 by 2 and 2'b10 by 4.
- R5: Stage C select codes: 2'b00 divides by 1, 2'b01 by 2 and 2'b10 by 5.
- R6: Select code 2'b11 on any stage passes its input through unchanged, the same as a ratio of 1.
- R7: `imclk_en_o` is high for exactly one cycle in every P cycles, where P is the product of the three stage ratios (1 to 60).
- R8: After a write in cycle t, the old schedule is discarded. The first `imclk_en_o` pulse comes in cycle t+P, where P comes from the new configuration, and the pulses stay P apart after that.
- R9: `fs_en_o` pulses together with every 256th `imclk_en_o` pulse, counted from reset or from the last write, and never on any other cycle.
- R10: While `cfg_we_i` is low, `cfg_wdata_i` has no effect on either strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Three 2-bit stage ratio selects |
| imclk_en_o | output | 1 | Internal master tick enable |
| fs_en_o | output | 1 | Sample-rate strobe |

## Verification
Both strobes are decoded from registered state only, so a pulse shows up in the same cycle as the counter state that causes it. A write that is sampled at a rising edge takes effect from the following cycle, and its first pulse comes P cycles after the write cycle. The bench drives inputs 1 ns after a falling edge and advances its reference model at every rising edge. It compares both strobes against the model at each falling edge, once the counter registers have settled and before any new stimulus is applied. For each cycle it works out from the configuration which strobe is due, rather than waiting for a pulse and checking afterwards.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int unsigned NUM_STAGES = 3;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned CFG_W      = NUM_STAGES * SEL_W;
  localparam int unsigned FS_DIV     = 256;

  typedef enum logic [SEL_W-1:0] {
    SEL_UNITY  = 2'b00,
    SEL_HALF   = 2'b01,
    SEL_WIDE   = 2'b10,
    SEL_BYPASS = 2'b11
  } sel_e;

  // largest ratio of each stage
  function automatic int unsigned wide_ratio(input int unsigned stage);
    case (stage)
      0:       return 3;
      1:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int unsigned stage_ratio(input int unsigned stage, input logic [SEL_W-1:0] sel);
    case (sel_e'(sel))
      SEL_HALF: return 2;
      SEL_WIDE: return wide_ratio(stage);
      default:  return 1;
    endcase
  endfunction

  localparam int unsigned MAX_TOTAL = wide_ratio(0) * wide_ratio(1) * wide_ratio(2);
  localparam int unsigned TOTAL_W   = $clog2(MAX_TOTAL + 1);
endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int unsigned RATIO_WIDE = 3,
  localparam int unsigned CNT_W     = (RATIO_WIDE > 2) ? $clog2(RATIO_WIDE) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  input  logic       in_en_i,
  output logic       out_en_o
);
  import prescale_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_cnt;
  logic             at_term;

  always_comb begin
    case (sel_e'(sel_i))
      SEL_HALF: term_cnt = CNT_W'(1);
      SEL_WIDE: term_cnt = CNT_W'(RATIO_WIDE - 1);
      default:  term_cnt = '0;
    endcase
  end

  assign at_term  = (cnt_q == term_cnt);
  assign out_en_o = in_en_i & at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (in_en_i) cnt_q <= at_term ? '0 : cnt_q + 1'b1;
  end

  AST_STAGE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> in_en_i) else $error("stage fired without input tick"); // R7

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term_cnt) else $error("stage counter beyond ratio"); // R6

  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0) else $error("stage not restarted by write"); // R8
endmodule

// File: rtl/sample_div.sv
module sample_div #(
  parameter int unsigned DIV    = 256,
  localparam int unsigned CNT_W = $clog2(DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic strobe_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_term;

  assign at_term  = (cnt_q == CNT_W'(DIV - 1));
  assign strobe_o = tick_i & at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= at_term ? '0 : cnt_q + 1'b1;
  end

  AST_FS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> cnt_q == '0) else $error("sample counter did not wrap"); // R9
endmodule

// File: rtl/mclk_prescaler.sv
module mclk_prescaler
  import prescale_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             imclk_en_o,
  output logic             fs_en_o
);
  logic [CFG_W-1:0]    cfg_q;
  logic                run_q;
  logic [NUM_STAGES:0] en_chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (cfg_we_i) cfg_q <= cfg_wdata_i;
    end
  end

  assign en_chain[0] = run_q;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    div_stage #(
      .RATIO_WIDE(wide_ratio(g))
    ) i_div_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cfg_we_i),
      .sel_i   (cfg_q[g*SEL_W +: SEL_W]),
      .in_en_i (en_chain[g]),
      .out_en_o(en_chain[g+1])
    );
  end

  assign imclk_en_o = en_chain[NUM_STAGES];

  sample_div #(
    .DIV(FS_DIV)
  ) i_sample_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_we_i),
    .tick_i  (imclk_en_o),
    .strobe_o(fs_en_o)
  );

  // period check: qualified cycles since last tick or write vs stage ratio product
  logic [TOTAL_W-1:0] gap_q;
  logic [TOTAL_W-1:0] total_m1;

  always_comb begin
    int unsigned prod;
    prod = 1;
    for (int unsigned i = 0; i < NUM_STAGES; i++)
      prod = prod * stage_ratio(i, cfg_q[i*SEL_W +: SEL_W]);
    total_m1 = TOTAL_W'(prod - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= '0;
    else if (cfg_we_i || imclk_en_o) gap_q <= '0;
    else if (run_q)                  gap_q <= gap_q + 1'b1;
  end

  AST_EVEN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imclk_en_o |-> gap_q == total_m1) else $error("tick period mismatch"); // R7

  AST_NO_LATE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && gap_q == total_m1) |-> imclk_en_o) else $error("tick missing"); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !imclk_en_o && !fs_en_o) else $error("strobe before start"); // R1

  AST_FS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_en_o |-> imclk_en_o) else $error("sample strobe off tick"); // R9
endmodule

// File: tb/test_mclk_prescaler.sv
`timescale 1ns/1ps
module test_mclk_prescaler;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [5:0] cfg_wdata_i = '0;
  logic       imclk_en_o;
  logic       fs_en_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  mclk_prescaler i_mclk_prescaler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .imclk_en_o (imclk_en_o),
    .fs_en_o    (fs_en_o)
  );

  always #10 clk_i = ~clk_i;

  // reference model
  int m_cfg = 0;
  int m_cnt = 0;
  int m_imc = 0;
  bit m_run = 0;

  function automatic int ratio_of(int stage, int code);
    int wide[3] = '{3, 4, 5};
    if (code == 1) return 2;
    if (code == 2) return wide[stage];
    return 1;
  endfunction

  function automatic int period_of(int cfg);
    int p = 1;
    for (int s = 0; s < 3; s++) p = p * ratio_of(s, (cfg >> (2*s)) & 3);
    return p;
  endfunction

  function automatic bit exp_tick();
    return rst_ni && m_run && (m_cnt == period_of(m_cfg) - 1);
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cfg = 0; m_cnt = 0; m_imc = 0; m_run = 0;
    end else begin
      bit t;
      t = exp_tick();
      if (cfg_we_i) begin
        m_cfg = int'(cfg_wdata_i); m_cnt = 0; m_imc = 0;
      end else if (m_run) begin
        if (t) begin m_cnt = 0; m_imc = (m_imc + 1) % 256; end
        else m_cnt++;
      end
      m_run = 1;
    end
  end

  always @(negedge clk_i) begin
    bit e_im, e_fs;
    if (!done) begin
      e_im = exp_tick();
      e_fs = e_im && (m_imc == 255);
      checks++;
      if (imclk_en_o !== e_im) begin
        failures++;
        $display("FAIL %s imclk_en_o act=%0b exp=%0b t=%0t", cur_req, imclk_en_o, e_im, $time);
      end
      checks++;
      if (fs_en_o !== e_fs) begin
        failures++;
        $display("FAIL %s fs_en_o act=%0b exp=%0b t=%0t", cur_req, fs_en_o, e_fs, $time);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [5:0] v);
    @(negedge clk_i); #1;
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    // R1: reset state and first cycle after release
    cur_req = "R1";
    run(5);
    @(negedge clk_i); #1; rst_ni = 1'b1;
    run(3);
    // R9 and R7 at ratio 1: fs on the 256th tick
    cur_req = "R9";
    run(600);
    // R3 R4 R5 R6: every code of every stage in isolation
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        case (s)
          0: cur_req = (c == 3) ? "R6" : "R3";
          1: cur_req = (c == 3) ? "R6" : "R4";
          default: cur_req = (c == 3) ? "R6" : "R5";
        endcase
        wr(6'(c << (2*s)));
        run(40);
      end
    end
    // R7: mixed products, R2 field mapping
    cur_req = "R7";
    wr(6'b011001); run(80);   // 2*3... A=01 B=10 C=01 -> 2*4*2
    wr(6'b100110); run(80);   // A=10 B=01 C=10 -> 3*2*5
    cur_req = "R2";
    wr(6'b111110); run(30);   // A=10 B=11 C=11 -> 3
    // R9 at the largest ratio
    cur_req = "R9";
    wr(6'b101010); run(60 * 256 + 200);
    // R8: write in mid-period and back-to-back writes
    cur_req = "R8";
    wr(6'b101010); run(37);
    wr(6'b000110); run(50);
    @(negedge clk_i); #1; cfg_we_i = 1'b1; cfg_wdata_i = 6'b100000;
    @(negedge clk_i); #1; cfg_wdata_i = 6'b000001;
    @(negedge clk_i); #1; cfg_we_i = 1'b0;
    run(40);
    // R10: data changes without write strobe
    cur_req = "R10";
    wr(6'b001001); run(5);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i); #1; cfg_wdata_i = 6'(k * 13 + 7);
      run(3);
    end
    run(20);
    // R1: reset in mid-run restores ratio 1
    cur_req = "R1";
    wr(6'b101010); run(23);
    @(negedge clk_i); #1; rst_ni = 1'b0;
    run(4);
    @(negedge clk_i); #1; rst_ni = 1'b1;
    run(300);
    finish_run();
  end
endmodule